// File: doc/BRIEF.md
# Digit-Serial BCD Register Store

This block models a small memory organised by decimal digit. It holds six multi-digit registers: an entry register, a working register, an accumulator and three temporary registers. Each stored digit is four bits with weights 8-4-2-1, and each bit lives in its own bit plane. One access names a register and a digit position, and runs as two timed phases. The read phase returns the digit and leaves the location at zero. The write phase then either restores the old digit or stores a new one. A per-plane inhibit mask can stop any plane from receiving a one.

The phases are timed by a fixed-width pulse counted in clock cycles. A sequencer uses the block by pulsing `start` while `busy` is low, and collects `rd_data` once `busy` falls. A master clear wipes the entry, working and accumulator registers in one cycle and leaves the temporary registers untouched.

Top module: `bcd_core_store`

## Requirements
- R1: After reset `busy`, `wr_phase` and `rd_data` are 0, and every location in every register reads as 0.
- R2: A `start` seen while `busy` is low is accepted at that edge. `busy` is then high for 2*PULSE_CYC cycles. `wr_phase` is 0 for the first PULSE_CYC of those cycles and 1 for the last PULSE_CYC.
- R3: A `start` raised while `busy` is high is ignored. The address, data and mask captured when the access was accepted stay in force, and no other location changes.
- R4: The read is destructive. At the end of the read phase `rd_data` takes the stored digit and the location becomes 0. It stays 0 unless the write phase puts ones back.
- R5: `wsel_new`=0 writes back the digit that was just read, and `wsel_new`=1 writes `wr_data`. Both values are sampled when the access is accepted.
- R6: Bit b of a digit (weight 1, 2, 4, 8 for b = 0..3) is written as 1 only when the chosen data bit b is 1 and `inhibit[b]` is 0. The stored digit is therefore data AND NOT inhibit.
- R7: Register addressing works as follows. With `reg_grp`=0, `reg_sel` 0/1/2 selects entry/working/accumulator. With `reg_grp`=1, `reg_sel` 1/2/3 selects temporary register 1/2/3. `digit_idx` (0..NUM_DIGITS-1) picks the digit, and every register/digit pair is independent.
- R8: The two unmapped codes (`reg_grp`=0 with `reg_sel`=3, and `reg_grp`=1 with `reg_sel`=0) read 0 and discard the write, with unchanged timing.
- R9: A one-cycle `mclr` zeroes every digit of the entry, working and accumulator registers and leaves all three temporary registers unchanged.
- R10: When `mclr` falls on the same edge that commits a write, the clear wins for a main register, and a write to a temporary register is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an access (taken only when idle) |
| reg_grp | input | 1 | 0 = main registers, 1 = temporary registers |
| reg_sel | input | 2 | Register select within the group |
| digit_idx | input | 5 | Digit position |
| wsel_new | input | 1 | 0 = restore read digit, 1 = store wr_data |
| wr_data | input | 4 | New digit for the write phase |
| inhibit | input | 4 | Per-plane inhibit mask, bit b blocks weight 2^b |
| mclr | input | 1 | Master clear of the main registers |
| busy | output | 1 | High from the read phase start to the write phase end |
| wr_phase | output | 1 | High during the write phase |
| rd_data | output | 4 | Digit returned by the last read |

## Verification
Master clear and the write commit of an access can land on the same clock edge. The bench provokes this by counting cycles from the accepted `start` and raising `mclr` for exactly the edge that ends the write phase. It does this once for a main-register target and once for a temporary target. It then judges the outcome by reading the locations back through normal accesses. The main location must read zero, and the temporary location must hold the new digit, while the other temporaries keep their contents.

// File: rtl/bcd_store_pkg.sv
package bcd_store_pkg;

  localparam int N_SLOTS = 6;
  localparam int N_MAIN  = 3;
  localparam int SLOT_W  = 3;

  typedef logic [3:0] bcd_digit_t;

  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
  } slot_dec_t;

  // Main group: 0 entry, 1 working, 2 accumulator. Temp group: 1..3 -> slots 3..5.
  function automatic slot_dec_t decode_slot(input logic grp, input logic [1:0] sel);
    slot_dec_t r;
    r.hit  = 1'b0;
    r.slot = '0;
    if (!grp) begin
      if (sel != 2'd3) begin
        r.hit  = 1'b1;
        r.slot = {1'b0, sel};
      end
    end else if (sel != 2'd0) begin
      r.hit  = 1'b1;
      r.slot = SLOT_W'(sel) + SLOT_W'(2);
    end
    return r;
  endfunction

  function automatic bcd_digit_t write_value(input logic use_new, input bcd_digit_t new_d,
                                             input bcd_digit_t old_d, input bcd_digit_t inh);
    return (use_new ? new_d : old_d) & ~inh;
  endfunction

endpackage

// File: rtl/bcd_addr_decode.sv
module bcd_addr_decode
  import bcd_store_pkg::*;
(
  input  logic              grp,
  input  logic [1:0]        sel,
  output logic              hit,
  output logic [SLOT_W-1:0] slot
);
  slot_dec_t d;
  always_comb begin
    d    = decode_slot(grp, sel);
    hit  = d.hit;
    slot = d.slot;
  end
endmodule

// File: rtl/bcd_phase_timer.sv
module bcd_phase_timer #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic wr_phase,
  output logic read_end,
  output logic write_end
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_t;
  phase_t      phase;
  logic [CW-1:0] cnt;
  logic        last;

  assign last      = (cnt == CW'(PULSE_CYC - 1));
  assign accept    = start && (phase == PH_IDLE);
  assign busy      = (phase != PH_IDLE);
  assign wr_phase  = (phase == PH_WRITE);
  assign read_end  = (phase == PH_READ) && last;
  assign write_end = (phase == PH_WRITE) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE:  if (accept) begin phase <= PH_READ; cnt <= '0; end
        PH_READ:  if (last) begin phase <= PH_WRITE; cnt <= '0; end
                  else cnt <= cnt + 1'b1;
        PH_WRITE: if (last) begin phase <= PH_IDLE; cnt <= '0; end
                  else cnt <= cnt + 1'b1;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  assert_accept_enters_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !wr_phase));
  assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    read_end |=> (busy && wr_phase));
  assert_busy_ends_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    write_end |=> !busy);
endmodule

// File: rtl/bcd_bit_plane.sv
module bcd_bit_plane #(
  parameter int DEPTH      = 192,
  parameter int MAIN_DEPTH = 96,
  parameter int IDX_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             rd_clear,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             clr_main,
  output logic             rd_bit
);
  logic [DEPTH-1:0] cells;

  assign rd_bit = cells[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells <= '0;
    end else begin
      if (rd_clear) cells[idx] <= 1'b0;
      if (wr_en)    cells[idx] <= wr_bit;
      if (clr_main) cells[MAIN_DEPTH-1:0] <= '0;
    end
  end

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_main && int'(idx) < MAIN_DEPTH) |=> !rd_bit);
endmodule

// File: rtl/bcd_core_store.sv
module bcd_core_store
  import bcd_store_pkg::*;
#(
  parameter int NUM_DIGITS = 32,
  parameter int PULSE_CYC  = 4,
  parameter int DIG_W      = $clog2(NUM_DIGITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             reg_grp,
  input  logic [1:0]       reg_sel,
  input  logic [DIG_W-1:0] digit_idx,
  input  logic             wsel_new,
  input  logic [3:0]       wr_data,
  input  logic [3:0]       inhibit,
  input  logic             mclr,
  output logic             busy,
  output logic             wr_phase,
  output logic [3:0]       rd_data
);
  localparam int DEPTH      = N_SLOTS * NUM_DIGITS;
  localparam int MAIN_DEPTH = N_MAIN * NUM_DIGITS;
  localparam int IDX_W      = $clog2(DEPTH);

  logic              accept, read_end, write_end;
  logic              dec_hit;
  logic [SLOT_W-1:0] dec_slot;
  logic              cur_hit, cur_new;
  logic [SLOT_W-1:0] cur_slot;
  logic [DIG_W-1:0]  cur_digit;
  bcd_digit_t        cur_wdata, cur_inh, cell_bits, wr_bits;
  logic [IDX_W-1:0]  cur_idx;
  logic              rd_fire, wr_fire;

  bcd_phase_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .busy(busy),
    .wr_phase(wr_phase), .read_end(read_end), .write_end(write_end)
  );

  bcd_addr_decode u_dec (.grp(reg_grp), .sel(reg_sel), .hit(dec_hit), .slot(dec_slot));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_hit   <= 1'b0;
      cur_new   <= 1'b0;
      cur_slot  <= '0;
      cur_digit <= '0;
      cur_wdata <= '0;
      cur_inh   <= '0;
    end else if (accept) begin
      cur_hit   <= dec_hit;
      cur_new   <= wsel_new;
      cur_slot  <= dec_slot;
      cur_digit <= digit_idx;
      cur_wdata <= wr_data;
      cur_inh   <= inhibit;
    end
  end

  assign cur_idx = IDX_W'(cur_slot) * IDX_W'(NUM_DIGITS) + IDX_W'(cur_digit);
  assign rd_fire = read_end && cur_hit;
  assign wr_fire = write_end && cur_hit;
  assign wr_bits = write_value(cur_new, cur_wdata, rd_data, cur_inh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rd_data <= '0;
    else if (read_end) rd_data <= cur_hit ? cell_bits : 4'd0;
  end

  for (genvar b = 0; b < 4; b++) begin : g_plane
    bcd_bit_plane #(.DEPTH(DEPTH), .MAIN_DEPTH(MAIN_DEPTH), .IDX_W(IDX_W)) u_plane (
      .clk(clk), .rst_n(rst_n), .idx(cur_idx), .rd_clear(rd_fire),
      .wr_en(wr_fire), .wr_bit(wr_bits[b]), .clr_main(mclr), .rd_bit(cell_bits[b])
    );
  end

  assert_read_destroys_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (cell_bits == 4'd0));
  assert_busy_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(cur_idx) && $stable(cur_wdata) && $stable(cur_inh)));
  assert_inhibit_blocks_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !mclr) |=> ((cell_bits & $past(cur_inh)) == 4'd0));
  assert_unmapped_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (read_end && !cur_hit) |=> (rd_data == 4'd0));
endmodule

// File: tb/bcd_core_store_tb.sv
module bcd_core_store_tb;
  localparam int ND = 32;
  localparam int P  = 4;

  logic clk = 0, rst_n = 0, start = 0, reg_grp = 0, wsel_new = 0, mclr = 0;
  logic [1:0] reg_sel = 0;
  logic [4:0] digit_idx = 0;
  logic [3:0] wr_data = 0, inhibit = 0;
  logic busy, wr_phase;
  logic [3:0] rd_data;

  int checks = 0, failures = 0;
  logic [3:0] model [6][ND];

  always #10 clk = ~clk;

  bcd_core_store #(.NUM_DIGITS(ND), .PULSE_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_grp(reg_grp), .reg_sel(reg_sel),
    .digit_idx(digit_idx), .wsel_new(wsel_new), .wr_data(wr_data), .inhibit(inhibit),
    .mclr(mclr), .busy(busy), .wr_phase(wr_phase), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // bench-side address map: returns -1 for unmapped codes
  function automatic int map_slot(input int grp, input int sel);
    if (grp == 0) return (sel < 3) ? sel : -1;
    return (sel > 0) ? sel + 2 : -1;
  endfunction

  task automatic launch(input int grp, input int sel, input int d, input bit nw,
                        input int data, input int inh);
    @(negedge clk);
    reg_grp = grp[0]; reg_sel = sel[1:0]; digit_idx = d[4:0];
    wsel_new = nw; wr_data = data[3:0]; inhibit = inh[3:0]; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // full access with model update and rd_data check
  task automatic acc(input int grp, input int sel, input int d, input bit nw,
                     input int data, input int inh, input string req);
    int s;
    logic [3:0] old;
    s = map_slot(grp, sel);
    old = (s < 0) ? 4'd0 : model[s][d];
    launch(grp, sel, d, nw, data, inh);
    while (busy) @(negedge clk);
    chk(rd_data == old, req, rd_data, old);
    if (s >= 0) model[s][d] = (nw ? data[3:0] : old) & ~inh[3:0];
  endtask

  task automatic read_all(input string req);
    for (int s = 0; s < 6; s++)
      for (int d = 0; d < ND; d++)
        acc((s < 3) ? 0 : 1, (s < 3) ? s : s - 2, d, 0, 0, 0, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < 6; s++) for (int d = 0; d < ND; d++) model[s][d] = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(busy == 0 && wr_phase == 0 && rd_data == 0, "R1", {busy, wr_phase, rd_data}, 0);
    read_all("R1");

    // R2: phase timing
    launch(0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 2 * P; k++) begin
      chk(busy == 1, "R2 busy", busy, 1);
      chk(wr_phase == (k >= P), "R2 wr_phase", wr_phase, (k >= P));
      @(negedge clk);
    end
    chk(busy == 0, "R2 idle", busy, 0);

    // R7/R5: fill every register/digit with new data, then restore-read twice
    for (int s = 0; s < 6; s++)
      for (int d = 0; d < ND; d++)
        acc((s < 3) ? 0 : 1, (s < 3) ? s : s - 2, d, 1, (s * 7 + d * 3 + 1) % 16, 0, "R7");
    read_all("R7");
    read_all("R5");

    // R8: unmapped codes
    acc(0, 3, 4, 1, 9, 0, "R8");
    acc(0, 3, 4, 0, 0, 0, "R8");
    acc(1, 0, 5, 1, 6, 0, "R8");
    acc(1, 0, 5, 0, 0, 0, "R8");
    acc(0, 0, 4, 0, 0, 0, "R8 neighbour");
    acc(1, 1, 5, 0, 0, 0, "R8 neighbour");

    // R4: full inhibit leaves a read location zero
    acc(0, 1, 7, 1, 15, 15, "R4");
    acc(0, 1, 7, 0, 0, 0, "R4");
    acc(0, 1, 7, 1, 15, 0, "R4");
    acc(0, 1, 7, 0, 0, 0, "R4");

    // R6: data x inhibit sweep, restore path also masked
    for (int dv = 0; dv < 16; dv++)
      for (int iv = 0; iv < 16; iv++) begin
        acc(1, 2, 9, 1, dv, iv, "R6");
        acc(1, 2, 9, 0, 0, 0, "R6");
      end
    acc(0, 2, 3, 1, 15, 0, "R6");
    acc(0, 2, 3, 0, 0, 6, "R6 restore");
    acc(0, 2, 3, 0, 0, 0, "R6 restore");

    // R3: start while busy is ignored
    launch(0, 2, 10, 1, 5, 0);
    reg_grp = 1; reg_sel = 3; digit_idx = 11; wr_data = 2; wsel_new = 1; start = 1;
    @(negedge clk);
    start = 0;
    while (busy) @(negedge clk);
    model[2][10] = 4'd5;
    chk(busy == 0, "R3", busy, 0);
    acc(0, 2, 10, 0, 0, 0, "R3");
    acc(1, 3, 11, 0, 0, 0, "R3");

    // R9: master clear keeps temporaries
    @(negedge clk); mclr = 1;
    @(negedge clk); mclr = 0;
    for (int s = 0; s < 3; s++) for (int d = 0; d < ND; d++) model[s][d] = 4'd0;
    read_all("R9");

    // R10: clear on the commit edge, main then temp target
    acc(0, 0, 12, 1, 3, 0, "R10 prep");
    launch(0, 0, 12, 1, 11, 0);
    repeat (2 * P - 1) @(negedge clk);
    mclr = 1;
    @(negedge clk); mclr = 0;
    for (int s = 0; s < 3; s++) for (int d = 0; d < ND; d++) model[s][d] = 4'd0;
    chk(busy == 0, "R10", busy, 0);
    acc(0, 0, 12, 0, 0, 0, "R10 main");
    launch(1, 3, 12, 1, 13, 0);
    repeat (2 * P - 1) @(negedge clk);
    mclr = 1;
    @(negedge clk); mclr = 0;
    model[5][12] = 4'd13;
    acc(1, 3, 12, 0, 0, 0, "R10 temp");
    acc(1, 1, 12, 0, 0, 0, "R10 temp other");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule